// File: doc/BRIEF.md
# Write-back cache write sequencer

This block sits between a small write buffer and an external write-back cache whose data path is 16 bytes wide and which accepts one access every five cycles. Each buffered write covers one 32-byte line. A flag for each 16-byte half marks which halves hold data. The block accepts entries from a requester into a four-entry FIFO and drives the `wr_full` stall signal when the FIFO is full. It retires the oldest entry through a fixed sequence of cache accesses.

Each entry starts with a lookup access. The lookup returns the line's stored tag and valid bit. On a match, the block issues one data-write access for each half that holds data, lower half first. A data-write access also marks the line dirty. When the entry's last write window closes, the entry leaves the buffer.

A failed lookup raises a miss pulse and writes nothing. The entry stays at the head of the buffer and is looked up again, so an external agent has time to install the line. The cache port is driven with single-cycle command pulses. The block waits out each five-cycle window before it issues the next command.

Top module: `wbc_write_seq`

## Requirements
- R1: After reset `cmd_valid`, `seq_done`, `seq_miss` and `wr_full` are 0, and `cmd_op` is 2'b00 whenever `cmd_valid` is 0.
- R2: Every entry starts with a lookup command (`cmd_op` = 2'b01) carrying the entry's line address on `cmd_line`. When the sequencer is idle and the buffer is empty, a push accepted in cycle p produces the lookup in cycle p+2.
- R3: Each access occupies ACC_CYC (5) cycles, counting its command cycle. No command is issued fewer than ACC_CYC cycles after the previous one, and after a hit the first data write comes exactly ACC_CYC cycles after the lookup.
- R4: The lookup result is sampled in the last cycle of its window. It is a hit only if `rd_line_vld` is 1 and `rd_tag` equals `cmd_line[LINE_W-1:IDX_W]`. A mismatched tag and a clear valid bit are both misses.
- R5: An entry with both halves flagged (`wr_halves` = 2'b11) gets two data writes (`cmd_op` = 2'b10). The first has `cmd_half` = 0 and data bits 127:0, at lookup+5. The second has `cmd_half` = 1 and data bits 255:128, at lookup+10. `seq_done` pulses at lookup+14.
- R6: An entry with one half flagged (bit 0 = lower, bit 1 = upper) gets exactly one data write, for that half only, at lookup+5. `seq_done` pulses at lookup+9.
- R7: On a miss, `seq_miss` pulses in the last lookup cycle (lookup+4) and no data write is issued. The entry stays at the head, and its lookup is issued again at lookup+6.
- R8: Entries retire in push order. An entry is removed only when `seq_done` pulses after its last data write.
- R9: The buffer holds DEPTH (4) entries. `wr_full` is 1 while four are held, and a push made while `wr_full` is 1 is dropped.
- R10: A push with `wr_halves` = 2'b00 is dropped and produces no cache access.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | Push a write entry this cycle |
| wr_line | input | LINE_W | Line address of the pushed entry |
| wr_data | input | 2*BEAT_W | 32 bytes of line data, lower half in the low bits |
| wr_halves | input | 2 | Half-has-data flags, bit 0 lower, bit 1 upper |
| wr_full | output | 1 | Buffer full, requester must stall |
| cmd_valid | output | 1 | Cache access command pulse |
| cmd_op | output | 2 | 2'b01 lookup, 2'b10 data write with dirty set, 2'b00 none |
| cmd_line | output | LINE_W | Line address of the access |
| cmd_half | output | 1 | Half selected by a data write |
| cmd_wdata | output | BEAT_W | 16-byte write beat |
| rd_tag | input | LINE_W-IDX_W | Stored tag returned by a lookup |
| rd_line_vld | input | 1 | Stored line valid bit returned by a lookup |
| seq_done | output | 1 | Head entry retired this cycle |
| seq_miss | output | 1 | Lookup missed this cycle |

## Verification
Faults in the internal state show up on the command port within one access window. A timer that is off by a cycle moves a data write or a second lookup away from the +5 and +6 offsets. A half register that is wrong drives the wrong beat or `cmd_half`, or drops the second beat, and then `seq_done` arrives five cycles early. Buffer pointer or pop faults appear a few accesses later, as the wrong line order, a repeated or missing entry, or `wr_full` asserted at the wrong occupancy. A bad hit compare shows up in the same cycle as a miss pulse or a write where none should be.

// File: rtl/wbc_pkg.sv
package wbc_pkg;

    typedef enum logic [1:0] {
        OP_NONE    = 2'b00,
        OP_TAG_RD  = 2'b01,
        OP_DATA_WR = 2'b10
    } cache_op_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_TAG_CMD,
        ST_TAG_WAIT,
        ST_WR_CMD,
        ST_WR_WAIT
    } seq_state_e;

endpackage

// File: rtl/wbc_wbuf.sv
module wbc_wbuf #(
    parameter int DEPTH  = 4,
    parameter int LINE_W = 16,
    parameter int BEAT_W = 128
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  push,
    input  logic [LINE_W-1:0]     push_line,
    input  logic [2*BEAT_W-1:0]   push_data,
    input  logic [1:0]            push_halves,
    input  logic                  pop,
    output logic                  full,
    output logic                  empty,
    output logic [LINE_W-1:0]     head_line,
    output logic [2*BEAT_W-1:0]   head_data,
    output logic [1:0]            head_halves
);
    localparam int PTR_W = $clog2(DEPTH);

    typedef struct packed {
        logic [PTR_W:0] wr_ptr;
        logic [PTR_W:0] rd_ptr;
    } ptr_t;

    ptr_t q, d;
    logic accept;

    logic [LINE_W-1:0]   line_mem   [DEPTH];
    logic [2*BEAT_W-1:0] data_mem   [DEPTH];
    logic [1:0]          halves_mem [DEPTH];

    always_comb begin
        d      = q;
        empty  = (q.wr_ptr == q.rd_ptr);
        full   = (q.wr_ptr[PTR_W] != q.rd_ptr[PTR_W]) &&
                 (q.wr_ptr[PTR_W-1:0] == q.rd_ptr[PTR_W-1:0]);
        accept = push && !full && (push_halves != 2'b00);
        if (accept) begin
            d.wr_ptr = q.wr_ptr + 1'b1;
        end
        if (pop && !empty) begin
            d.rd_ptr = q.rd_ptr + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    always_ff @(posedge clk) begin
        if (accept) begin
            line_mem[q.wr_ptr[PTR_W-1:0]]   <= push_line;
            data_mem[q.wr_ptr[PTR_W-1:0]]   <= push_data;
            halves_mem[q.wr_ptr[PTR_W-1:0]] <= push_halves;
        end
    end

    assign head_line   = line_mem[q.rd_ptr[PTR_W-1:0]];
    assign head_data   = data_mem[q.rd_ptr[PTR_W-1:0]];
    assign head_halves = halves_mem[q.rd_ptr[PTR_W-1:0]];

endmodule

// File: rtl/wbc_acc_timer.sv
module wbc_acc_timer #(
    parameter int ACC_CYC = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic last
);
    localparam int CNT_W = $clog2(ACC_CYC + 1);

    typedef struct packed {
        logic             active;
        logic [CNT_W-1:0] cnt;
    } tmr_t;

    tmr_t q, d;

    always_comb begin
        d    = q;
        last = q.active && (q.cnt == CNT_W'(ACC_CYC - 1));
        if (start) begin
            d.active = 1'b1;
            d.cnt    = CNT_W'(1);
        end else if (last) begin
            d.active = 1'b0;
            d.cnt    = '0;
        end else if (q.active) begin
            d.cnt = q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

endmodule

// File: rtl/wbc_seq_fsm.sv
module wbc_seq_fsm
    import wbc_pkg::*;
#(
    parameter int LINE_W = 16,
    parameter int IDX_W  = 8,
    parameter int BEAT_W = 128
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      head_valid,
    input  logic [LINE_W-1:0]         head_line,
    input  logic [2*BEAT_W-1:0]       head_data,
    input  logic [1:0]                head_halves,
    input  logic [LINE_W-IDX_W-1:0]   rd_tag,
    input  logic                      rd_line_vld,
    input  logic                      tmr_last,
    output logic                      cmd_valid,
    output cache_op_e                 cmd_op,
    output logic                      cmd_half,
    output logic [BEAT_W-1:0]         cmd_wdata,
    output logic                      seq_done,
    output logic                      seq_miss
);
    typedef struct packed {
        seq_state_e st;
        logic       half;
    } fsm_t;

    fsm_t q, d;
    logic tag_hit;

    always_comb begin
        d         = q;
        cmd_valid = 1'b0;
        cmd_op    = OP_NONE;
        cmd_half  = 1'b0;
        cmd_wdata = '0;
        seq_done  = 1'b0;
        seq_miss  = 1'b0;
        tag_hit   = rd_line_vld && (rd_tag == head_line[LINE_W-1:IDX_W]);
        case (q.st)
            ST_IDLE: begin
                if (head_valid) begin
                    d.st = ST_TAG_CMD;
                end
            end
            ST_TAG_CMD: begin
                cmd_valid = 1'b1;
                cmd_op    = OP_TAG_RD;
                d.st      = ST_TAG_WAIT;
            end
            ST_TAG_WAIT: begin
                if (tmr_last) begin
                    if (tag_hit) begin
                        d.half = !head_halves[0];
                        d.st   = ST_WR_CMD;
                    end else begin
                        seq_miss = 1'b1;
                        d.st     = ST_IDLE;
                    end
                end
            end
            ST_WR_CMD: begin
                cmd_valid = 1'b1;
                cmd_op    = OP_DATA_WR;
                cmd_half  = q.half;
                cmd_wdata = q.half ? head_data[2*BEAT_W-1:BEAT_W]
                                   : head_data[BEAT_W-1:0];
                d.st      = ST_WR_WAIT;
            end
            ST_WR_WAIT: begin
                if (tmr_last) begin
                    if (!q.half && head_halves[1]) begin
                        d.half = 1'b1;
                        d.st   = ST_WR_CMD;
                    end else begin
                        seq_done = 1'b1;
                        d.half   = 1'b0;
                        d.st     = ST_IDLE;
                    end
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '{st: ST_IDLE, half: 1'b0};
        end else begin
            q <= d;
        end
    end

endmodule

// File: rtl/wbc_write_seq.sv
module wbc_write_seq
    import wbc_pkg::*;
#(
    parameter int LINE_W  = 16,
    parameter int IDX_W   = 8,
    parameter int BEAT_W  = 128,
    parameter int DEPTH   = 4,
    parameter int ACC_CYC = 5,
    localparam int TAG_W  = LINE_W - IDX_W
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_valid,
    input  logic [LINE_W-1:0]     wr_line,
    input  logic [2*BEAT_W-1:0]   wr_data,
    input  logic [1:0]            wr_halves,
    output logic                  wr_full,
    output logic                  cmd_valid,
    output logic [1:0]            cmd_op,
    output logic [LINE_W-1:0]     cmd_line,
    output logic                  cmd_half,
    output logic [BEAT_W-1:0]     cmd_wdata,
    input  logic [TAG_W-1:0]      rd_tag,
    input  logic                  rd_line_vld,
    output logic                  seq_done,
    output logic                  seq_miss
);
    logic                head_empty;
    logic [LINE_W-1:0]   head_line;
    logic [2*BEAT_W-1:0] head_data;
    logic [1:0]          head_halves;
    logic                tmr_last;
    cache_op_e           op_int;

    wbc_wbuf #(
        .DEPTH (DEPTH),
        .LINE_W(LINE_W),
        .BEAT_W(BEAT_W)
    ) u_wbuf (
        .clk        (clk),
        .rst_n      (rst_n),
        .push       (wr_valid),
        .push_line  (wr_line),
        .push_data  (wr_data),
        .push_halves(wr_halves),
        .pop        (seq_done),
        .full       (wr_full),
        .empty      (head_empty),
        .head_line  (head_line),
        .head_data  (head_data),
        .head_halves(head_halves)
    );

    wbc_acc_timer #(
        .ACC_CYC(ACC_CYC)
    ) u_timer (
        .clk  (clk),
        .rst_n(rst_n),
        .start(cmd_valid),
        .last (tmr_last)
    );

    wbc_seq_fsm #(
        .LINE_W(LINE_W),
        .IDX_W (IDX_W),
        .BEAT_W(BEAT_W)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .head_valid (!head_empty),
        .head_line  (head_line),
        .head_data  (head_data),
        .head_halves(head_halves),
        .rd_tag     (rd_tag),
        .rd_line_vld(rd_line_vld),
        .tmr_last   (tmr_last),
        .cmd_valid  (cmd_valid),
        .cmd_op     (op_int),
        .cmd_half   (cmd_half),
        .cmd_wdata  (cmd_wdata),
        .seq_done   (seq_done),
        .seq_miss   (seq_miss)
    );

    assign cmd_op   = op_int;
    assign cmd_line = head_line;

endmodule

// File: rtl/wbc_write_seq_chk.sv
module wbc_write_seq_chk
    import wbc_pkg::*;
#(
    parameter int ACC_CYC = 5,
    parameter int DEPTH   = 4
) (
    input logic       clk,
    input logic       rst_n,
    input logic       wr_valid,
    input logic [1:0] wr_halves,
    input logic       wr_full,
    input logic       cmd_valid,
    input logic [1:0] cmd_op,
    input logic       cmd_half,
    input logic       seq_done,
    input logic       seq_miss
);
    localparam int GAP_W = $clog2(ACC_CYC + 1);
    localparam int OCC_W = $clog2(DEPTH + 1);

    logic [GAP_W-1:0] gap_q;
    logic [OCC_W-1:0] occ_q;
    logic [1:0]       last_op_q;
    logic             last_half_q;
    logic             missed_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gap_q       <= GAP_W'(ACC_CYC);
            occ_q       <= '0;
            last_op_q   <= OP_NONE;
            last_half_q <= 1'b0;
            missed_q    <= 1'b0;
        end else begin
            if (cmd_valid) begin
                gap_q       <= GAP_W'(1);
                last_op_q   <= cmd_op;
                last_half_q <= cmd_half;
            end else if (gap_q < GAP_W'(ACC_CYC)) begin
                gap_q <= gap_q + 1'b1;
            end
            if (seq_miss) begin
                missed_q <= 1'b1;
            end else if (cmd_valid && cmd_op == OP_TAG_RD) begin
                missed_q <= 1'b0;
            end
            occ_q <= occ_q
                   + OCC_W'(wr_valid && !wr_full && (wr_halves != 2'b00))
                   - OCC_W'(seq_done);
        end
    end

    p_idle_op_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_valid |-> (cmd_op == OP_NONE));

    p_legal_op_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> (cmd_op == OP_TAG_RD || cmd_op == OP_DATA_WR));

    p_cmd_gap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> (gap_q >= GAP_W'(ACC_CYC)));

    p_write_after_lookup_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == OP_DATA_WR) |->
            (last_op_q == OP_TAG_RD) ||
            (last_op_q == OP_DATA_WR && !last_half_q && cmd_half));

    p_no_write_on_miss_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == OP_DATA_WR) |-> !missed_q);

    p_done_miss_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !(seq_done && seq_miss));

    p_done_after_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
        seq_done |-> (last_op_q == OP_DATA_WR));

    p_full_level_r9: assert property (@(posedge clk) disable iff (!rst_n)
        wr_full == (occ_q == OCC_W'(DEPTH)));

endmodule

bind wbc_write_seq wbc_write_seq_chk #(
    .ACC_CYC(ACC_CYC),
    .DEPTH  (DEPTH)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_valid (wr_valid),
    .wr_halves(wr_halves),
    .wr_full  (wr_full),
    .cmd_valid(cmd_valid),
    .cmd_op   (cmd_op),
    .cmd_half (cmd_half),
    .seq_done (seq_done),
    .seq_miss (seq_miss)
);

// File: tb/wbc_write_seq_tb.sv
module wbc_write_seq_tb;
    localparam int CLK_P   = 10;
    localparam int LINE_W  = 16;
    localparam int IDX_W   = 8;
    localparam int BEAT_W  = 128;
    localparam int DEPTH   = 4;
    localparam int ACC_CYC = 5;
    localparam int TAG_W   = LINE_W - IDX_W;

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic                wr_valid = 1'b0;
    logic [LINE_W-1:0]   wr_line = '0;
    logic [2*BEAT_W-1:0] wr_data = '0;
    logic [1:0]          wr_halves = '0;
    logic                wr_full;
    logic                cmd_valid;
    logic [1:0]          cmd_op;
    logic [LINE_W-1:0]   cmd_line;
    logic                cmd_half;
    logic [BEAT_W-1:0]   cmd_wdata;
    logic [TAG_W-1:0]    rd_tag = '0;
    logic                rd_line_vld = 1'b0;
    logic                seq_done;
    logic                seq_miss;

    wbc_write_seq #(
        .LINE_W (LINE_W),
        .IDX_W  (IDX_W),
        .BEAT_W (BEAT_W),
        .DEPTH  (DEPTH),
        .ACC_CYC(ACC_CYC)
    ) u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_valid   (wr_valid),
        .wr_line    (wr_line),
        .wr_data    (wr_data),
        .wr_halves  (wr_halves),
        .wr_full    (wr_full),
        .cmd_valid  (cmd_valid),
        .cmd_op     (cmd_op),
        .cmd_line   (cmd_line),
        .cmd_half   (cmd_half),
        .cmd_wdata  (cmd_wdata),
        .rd_tag     (rd_tag),
        .rd_line_vld(rd_line_vld),
        .seq_done   (seq_done),
        .seq_miss   (seq_miss)
    );

    always #(CLK_P/2) clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int                ev_cyc  [64];
    logic [1:0]        ev_op   [64];
    logic              ev_half [64];
    logic [LINE_W-1:0] ev_line [64];
    logic [BEAT_W-1:0] ev_data [64];
    int                done_cyc[64];
    int                miss_cyc[64];
    int n_ev = 0, n_done = 0, n_miss = 0;
    int n_checks = 0, n_fail = 0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (cmd_valid && n_ev < 64) begin
                ev_cyc[n_ev]  = cyc;
                ev_op[n_ev]   = cmd_op;
                ev_half[n_ev] = cmd_half;
                ev_line[n_ev] = cmd_line;
                ev_data[n_ev] = cmd_wdata;
                n_ev++;
            end
            if (seq_done && n_done < 64) begin
                done_cyc[n_done] = cyc;
                n_done++;
            end
            if (seq_miss && n_miss < 64) begin
                miss_cyc[n_miss] = cyc;
                n_miss++;
            end
        end
    end

    task automatic chk(input string req, input string what,
                       input logic [255:0] act, input logic [255:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    task automatic drive_push(input logic [LINE_W-1:0] line,
                              input logic [2*BEAT_W-1:0] data,
                              input logic [1:0] halves, output int pc);
        pc        = cyc;
        wr_valid  = 1'b1;
        wr_line   = line;
        wr_data   = data;
        wr_halves = halves;
        @(negedge clk);
        #1;
        wr_valid = 1'b0;
    endtask

    function automatic logic [2*BEAT_W-1:0] pattern(input logic [7:0] s);
        logic [2*BEAT_W-1:0] v;
        for (int i = 0; i < 2*BEAT_W/8; i++) v[i*8 +: 8] = s + 8'(i * 7);
        return v;
    endfunction

    task automatic t_reset;
        chk("R1", "cmd_valid", cmd_valid, 0);
        chk("R1", "cmd_op", cmd_op, 0);
        chk("R1", "wr_full", wr_full, 0);
        chk("R1", "seq_done", seq_done, 0);
        chk("R1", "seq_miss", seq_miss, 0);
    endtask

    task automatic t_full_line;
        int p, b, bd, bm;
        logic [2*BEAT_W-1:0] d = pattern(8'h11);
        b = n_ev; bd = n_done; bm = n_miss;
        rd_tag = 8'h3C; rd_line_vld = 1'b1;
        drive_push(16'h3C05, d, 2'b11, p);
        wait_n(25);
        chk("R2", "full: event count", n_ev - b, 3);
        chk("R2", "full: lookup op", ev_op[b], 2'b01);
        chk("R2", "full: lookup cycle", ev_cyc[b] - p, 2);
        chk("R2", "full: lookup line", ev_line[b], 16'h3C05);
        chk("R3", "full: first write offset", ev_cyc[b+1] - ev_cyc[b], ACC_CYC);
        chk("R5", "full: first write op", ev_op[b+1], 2'b10);
        chk("R5", "full: first half", ev_half[b+1], 0);
        chk("R5", "full: first beat", ev_data[b+1], d[127:0]);
        chk("R5", "full: second write offset", ev_cyc[b+2] - ev_cyc[b], 10);
        chk("R5", "full: second half", ev_half[b+2], 1);
        chk("R5", "full: second beat", ev_data[b+2], d[255:128]);
        chk("R5", "full: done count", n_done - bd, 1);
        chk("R5", "full: done offset", done_cyc[bd] - ev_cyc[b], 14);
        chk("R4", "full: no miss on hit", n_miss - bm, 0);
    endtask

    task automatic t_one_half(input logic [1:0] halves, input logic [7:0] seed);
        int p, b, bd;
        logic [2*BEAT_W-1:0] d = pattern(seed);
        logic h = halves[1];
        b = n_ev; bd = n_done;
        rd_tag = 8'h51; rd_line_vld = 1'b1;
        drive_push({8'h51, seed}, d, halves, p);
        wait_n(20);
        chk("R6", "single: event count", n_ev - b, 2);
        chk("R6", "single: write offset", ev_cyc[b+1] - ev_cyc[b], ACC_CYC);
        chk("R6", "single: half", ev_half[b+1], h);
        chk("R6", "single: beat", ev_data[b+1], h ? d[255:128] : d[127:0]);
        chk("R6", "single: done offset", done_cyc[bd] - ev_cyc[b], 9);
    endtask

    task automatic t_miss(input logic use_tag_mismatch);
        int p, b, bd, bm;
        b = n_ev; bd = n_done; bm = n_miss;
        rd_tag      = use_tag_mismatch ? 8'h78 : 8'h77;
        rd_line_vld = use_tag_mismatch;
        drive_push(16'h7709, pattern(8'h40), 2'b01, p);
        wait_n(6);
        rd_tag = 8'h77; rd_line_vld = 1'b1;
        wait_n(20);
        chk("R7", "miss: miss count", n_miss - bm, 1);
        chk("R7", "miss: miss cycle", miss_cyc[bm] - p, 6);
        chk("R7", "miss: event count", n_ev - b, 3);
        chk("R7", "miss: retry op", ev_op[b+1], 2'b01);
        chk("R7", "miss: retry offset", ev_cyc[b+1] - ev_cyc[b], 6);
        chk("R7", "miss: entry retained", ev_line[b+1], 16'h7709);
        chk("R4", "miss: write after hit", ev_cyc[b+2] - p, 13);
        chk("R4", "miss: done cycle", done_cyc[bd] - p, 17);
    endtask

    task automatic t_order_capacity;
        int p, tmp, b, bd;
        b = n_ev; bd = n_done;
        rd_tag = 8'h2A; rd_line_vld = 1'b1;
        drive_push(16'h2A00, pattern(8'h00), 2'b01, p);
        drive_push(16'h2A01, pattern(8'h01), 2'b01, tmp);
        drive_push(16'h2A02, pattern(8'h02), 2'b01, tmp);
        drive_push(16'h2A03, pattern(8'h03), 2'b01, tmp);
        chk("R9", "full after four", wr_full, 1);
        drive_push(16'h2AFF, pattern(8'hFF), 2'b01, tmp);
        wait_n(80);
        chk("R9", "event count with dropped push", n_ev - b, 8);
        chk("R8", "done count", n_done - bd, 4);
        chk("R9", "full cleared", wr_full, 0);
        for (int k = 0; k < 4; k++) begin
            chk("R8", "lookup line order", ev_line[b+2*k], 16'h2A00 + 16'(k));
            chk("R8", "write line order", ev_line[b+2*k+1], 16'h2A00 + 16'(k));
        end
        chk("R8", "third entry beat", ev_data[b+5], pattern(8'h02) & {128'b0, {128{1'b1}}});
        for (int k = 1; k < 8; k++) begin
            chk("R3", "command spacing", (ev_cyc[b+k] - ev_cyc[b+k-1]) >= ACC_CYC, 1);
        end
    endtask

    task automatic t_empty_halves;
        int p, b, bd;
        b = n_ev; bd = n_done;
        rd_tag = 8'h66; rd_line_vld = 1'b1;
        drive_push(16'h6601, pattern(8'h90), 2'b00, p);
        wait_n(20);
        chk("R10", "no access for empty entry", n_ev - b, 0);
        chk("R10", "no done for empty entry", n_done - bd, 0);
        drive_push(16'h6602, pattern(8'h91), 2'b10, p);
        wait_n(20);
        chk("R10", "next entry is first", ev_line[b], 16'h6602);
        chk("R10", "next entry lookup cycle", ev_cyc[b] - p, 2);
    endtask

    initial begin
        #(CLK_P * 200000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        #1;
        t_reset();
        rst_n = 1'b1;
        wait_n(2);
        t_reset();
        t_full_line();
        t_one_half(2'b10, 8'hA0);
        t_one_half(2'b01, 8'hB0);
        t_miss(1'b1);
        t_miss(1'b0);
        t_order_capacity();
        t_empty_halves();
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

endmodule